// File: doc/BRIEF.md
# Prescaled Timer-Counter with Phase Synchronizer

This block is a 16-bit up-counter that can be read and written one byte at a time. It has two time bases. The first is an internal tick that fires once per instruction cycle, which is four oscillator clocks long. The second is an external clock taken from one of two input pins.

The external clock first passes through an edge-counting prescaler that divides it by 1, 2, 4 or 8. The divided clock then goes one of two ways. It can increment the count directly. It can also pass through a synchronizer that samples it only at two fixed phases of the instruction cycle.

A sticky flag records every wrap of the count from all ones to zero. The flag is cleared only by an explicit write of 0. A sleep input stops the internal tick and the synchronizer. In sleep, the prescaler keeps counting pin edges, and so does an unsynchronized external count.

The control byte has this layout:
- bit 0: run
- bit 1: external source
- bit 2: bypass synchronizer
- bit 3: pin select
- bits 5:4: prescale code
- bits 7:6: ignored

Top module: `tmr_presc_counter`

## Requirements
- R1: After reset the count is 0x0000, the overflow flag is 0 and the control byte is 0 (internal source, stopped).
- R2: With run=1 and the external-source bit 0, the count rises by exactly one every four clocks, whatever the value of the bypass bit.
- R3: With the external-source bit 1, only rising edges of the selected pin are counted. Pin select 1 chooses ext_a_i and pin select 0 chooses ext_b_i; the other pin has no effect.
- R4: The prescale code p gives division N = 2^p. After e pin edges counted from a cleared prescaler, the count has risen by floor((e + N/2) / N).
- R5: With the bypass bit 1, external counting goes on while sleep_i is high. With the external-source bit 0, the count holds while sleep_i is high.
- R6: With the bypass bit 0, edges that occur while sleep_i is high are never counted, not even after wake-up. The prescaler keeps counting those edges.
- R7: With the bypass bit 0, the count can change only in the clock cycles whose phase index is 1 or 3 (the phase index is a free-running 2-bit counter).
- R8: With run=0, the count holds unless a byte is written.
- R9: A wrap of the count from 0xFFFF to 0x0000 sets the overflow flag. The flag stays set until a write with ovf_wdata_i=0.
- R10: A byte write loads that byte of the count, takes priority over an increment in the same cycle, and clears the prescaler.
- R11: A control write that changes the prescale code clears the prescaler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low reset |
| ext_a_i | input | 1 | External clock pin A (pin select = 1) |
| ext_b_i | input | 1 | External clock pin B (pin select = 0) |
| sleep_i | input | 1 | Sleep request |
| ctrl_we_i | input | 1 | Control byte write strobe |
| ctrl_wdata_i | input | 8 | Control byte |
| cnt_lo_we_i | input | 1 | Low count byte write strobe |
| cnt_hi_we_i | input | 1 | High count byte write strobe |
| cnt_wdata_i | input | 8 | Count byte write data |
| ovf_we_i | input | 1 | Overflow flag write strobe |
| ovf_wdata_i | input | 1 | Overflow flag write value |
| cnt_lo_o | output | 8 | Count, low byte |
| cnt_hi_o | output | 8 | Count, high byte |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
The assertions check the following on every cycle:
- the count holds while stopped, and otherwise steps by at most one;
- the overflow flag is set by a wrap and is sticky;
- byte writes take effect;
- synchronized increments fall only on the two sampling phases and never during sleep;
- the prescaler moves only on pin edges.

Only the bench scenarios can show the end-to-end quantities:
- the exact rate of one increment per four clocks;
- the divided edge totals for each prescale code and pin choice;
- that an edge swallowed during sleep stays lost after wake-up while the prescaler still advanced;
- that rewriting the prescale code or a count byte discards partial prescaler progress.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   localparam int PS_W    = 2;
   localparam int PHASE_W = 2;

   typedef struct packed {
      logic [PS_W-1:0] ps;
      logic            pin_sel;
      logic            bypass;
      logic            ext_src;
      logic            run;
   } ctrl_t;

   localparam int CTRL_BITS = $bits(ctrl_t);
endpackage

// File: rtl/tmr_phase.sv
module tmr_phase #(
   parameter int PHASE_W = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   output logic [PHASE_W-1:0] phase_o
);
   if (PHASE_W < 2) begin : g_chk
      $error("tmr_phase: PHASE_W must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) phase_o <= '0;
      else        phase_o <= phase_o + 1'b1;
   end

   // R2: each instruction cycle walks through every phase in order
   assert_phase_walk_R2: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> phase_o == $past(phase_o) + 1'b1);
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
   parameter int PS_W = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            pin_i,
   input  logic            clr_i,
   input  logic [PS_W-1:0] ps_i,
   output logic            out_o
);
   localparam int TAPS  = 1 << PS_W;
   localparam int DIV_W = TAPS - 1;

   if (PS_W < 1 || PS_W > 4) begin : g_chk
      $error("tmr_prescaler: PS_W out of range");
   end

   logic             pin_q1, pin_q2;
   logic [DIV_W-1:0] div_q;
   logic [TAPS-1:0]  taps;
   logic             pin_rise;

   assign pin_rise = pin_q1 & ~pin_q2;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pin_q1 <= 1'b0;
         pin_q2 <= 1'b0;
         div_q  <= '0;
      end else begin
         pin_q1 <= pin_i;
         pin_q2 <= pin_q1;
         if (clr_i)         div_q <= '0;
         else if (pin_rise) div_q <= div_q + 1'b1;
      end
   end

   assign taps[0] = pin_q1;
   for (genvar k = 1; k < TAPS; k++) begin : g_tap
      assign taps[k] = div_q[k-1];
   end
   assign out_o = taps[ps_i];

   // R4: the divider advances only on a pin edge
   assert_psc_edges_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && !pin_rise) |=> $stable(div_q));
endmodule

// File: rtl/tmr_sync.sv
module tmr_sync #(
   parameter int PHASE_W = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               lvl_i,
   input  logic [PHASE_W-1:0] phase_i,
   input  logic               sleep_i,
   input  logic               bypass_i,
   output logic               inc_o
);
   localparam logic [PHASE_W-1:0] PH_LAST = {PHASE_W{1'b1}};
   localparam logic [PHASE_W-1:0] PH_MID  = PH_LAST >> 1;

   logic held_q;
   logic sample;
   logic blocked;

   assign blocked = sleep_i & ~bypass_i;
   assign sample  = bypass_i | sleep_i | (phase_i == PH_MID) | (phase_i == PH_LAST);
   assign inc_o   = sample & ~blocked & lvl_i & ~held_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      held_q <= 1'b0;
      else if (sample) held_q <= lvl_i;
   end

   // R7: synchronized increments land only on the two sampling phases
   assert_sync_phase_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_o && !bypass_i) |-> (phase_i == PH_MID || phase_i == PH_LAST));
   // R6: the synchronizer produces nothing while asleep
   assert_sync_sleep_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (sleep_i && !bypass_i) |-> !inc_o);
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
   parameter int CNT_W  = 16,
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run_i,
   input  logic              inc_i,
   input  logic [NB-1:0]     byte_we_i,
   input  logic [BYTE_W-1:0] wdata_i,
   input  logic              ovf_we_i,
   input  logic              ovf_wdata_i,
   output logic [CNT_W-1:0]  cnt_o,
   output logic              ovf_o
);
   localparam int NB = CNT_W / BYTE_W;

   if (CNT_W % BYTE_W != 0) begin : g_chk
      $error("tmr_count: CNT_W must be a multiple of BYTE_W");
   end

   logic step;
   logic any_we;

   assign any_we = |byte_we_i;
   assign step   = run_i & inc_i & ~any_we;

   for (genvar b = 0; b < NB; b++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)            cnt_o[b*BYTE_W +: BYTE_W] <= '0;
         else if (byte_we_i[b]) cnt_o[b*BYTE_W +: BYTE_W] <= wdata_i;
         else if (step)         cnt_o[b*BYTE_W +: BYTE_W] <= cnt_o[b*BYTE_W +: BYTE_W] +
                                   BYTE_W'((b == 0) ? 1 : &cnt_o[b*BYTE_W-1:0]);
      end

      // R10: a written byte always lands, even over an increment
      assert_byte_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
         byte_we_i[b] |=> cnt_o[b*BYTE_W +: BYTE_W] == $past(wdata_i));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                ovf_o <= 1'b0;
      else if (step && &cnt_o)   ovf_o <= 1'b1;
      else if (ovf_we_i)         ovf_o <= ovf_wdata_i;
   end

   // R8: stopped and unwritten, the count holds
   assert_hold_stopped_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_i && !any_we) |=> $stable(cnt_o));
   // R2: without writes the count moves by at most one
   assert_single_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !any_we |=> (cnt_o == $past(cnt_o) || cnt_o == $past(cnt_o) + 1'b1));
   // R9: a wrap raises the flag
   assert_ovf_on_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(step) && $past(&cnt_o)) |-> (ovf_o && cnt_o == '0));
   // R9: the flag falls only through an explicit write of 0
   assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_o && !(ovf_we_i && !ovf_wdata_i)) |=> ovf_o);
endmodule

// File: rtl/tmr_presc_counter.sv
module tmr_presc_counter
   import tmr_pkg::*;
#(
   parameter int CNT_W  = 16,
   parameter int BYTE_W = 8,
   parameter int CTRL_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ext_a_i,
   input  logic              ext_b_i,
   input  logic              sleep_i,
   input  logic              ctrl_we_i,
   input  logic [CTRL_W-1:0] ctrl_wdata_i,
   input  logic              cnt_lo_we_i,
   input  logic              cnt_hi_we_i,
   input  logic [BYTE_W-1:0] cnt_wdata_i,
   input  logic              ovf_we_i,
   input  logic              ovf_wdata_i,
   output logic [BYTE_W-1:0] cnt_lo_o,
   output logic [BYTE_W-1:0] cnt_hi_o,
   output logic              ovf_o
);
   localparam logic [PHASE_W-1:0] PH_TICK = {PHASE_W{1'b1}};

   if (CNT_W != 2 * BYTE_W) begin : g_chk_cnt
      $error("tmr_presc_counter: count must be exactly two bytes");
   end
   if (CTRL_W <= CTRL_BITS) begin : g_chk_ctrl
      $error("tmr_presc_counter: control byte too narrow");
   end

   ctrl_t               ctrl_q, ctrl_new;
   logic [PHASE_W-1:0]  phase;
   logic                ext_pin;
   logic                psc_out;
   logic                psc_clr;
   logic                sync_inc;
   logic                inc_req;
   logic [CNT_W-1:0]    cnt;
   logic                unused_ctrl_hi;

   assign ctrl_new       = ctrl_t'(ctrl_wdata_i[CTRL_BITS-1:0]);
   assign unused_ctrl_hi = ^ctrl_wdata_i[CTRL_W-1:CTRL_BITS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         ctrl_q <= '0;
      else if (ctrl_we_i) ctrl_q <= ctrl_new;
   end

   assign ext_pin = ctrl_q.pin_sel ? ext_a_i : ext_b_i;
   assign psc_clr = cnt_lo_we_i | cnt_hi_we_i | (ctrl_we_i && ctrl_new.ps != ctrl_q.ps);

   tmr_phase #(.PHASE_W(PHASE_W)) u_phase (
      .clk(clk), .rst_n(rst_n), .phase_o(phase));

   tmr_prescaler #(.PS_W(PS_W)) u_psc (
      .clk(clk), .rst_n(rst_n), .pin_i(ext_pin), .clr_i(psc_clr),
      .ps_i(ctrl_q.ps), .out_o(psc_out));

   tmr_sync #(.PHASE_W(PHASE_W)) u_sync (
      .clk(clk), .rst_n(rst_n), .lvl_i(psc_out), .phase_i(phase),
      .sleep_i(sleep_i), .bypass_i(ctrl_q.bypass), .inc_o(sync_inc));

   assign inc_req = ctrl_q.ext_src ? sync_inc : (phase == PH_TICK && !sleep_i);

   tmr_count #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .run_i(ctrl_q.run), .inc_i(inc_req),
      .byte_we_i({cnt_hi_we_i, cnt_lo_we_i}), .wdata_i(cnt_wdata_i),
      .ovf_we_i(ovf_we_i), .ovf_wdata_i(ovf_wdata_i),
      .cnt_o(cnt), .ovf_o(ovf_o));

   assign cnt_lo_o = cnt[BYTE_W-1:0];
   assign cnt_hi_o = cnt[CNT_W-1:BYTE_W];

   // R5: the internal time base stops in sleep
   assert_timer_sleep_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_q.ext_src && sleep_i && !cnt_lo_we_i && !cnt_hi_we_i) |=> $stable(cnt));
endmodule

// File: tb/sim_tmr_presc_counter.sv
module sim_tmr_presc_counter;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ext_a = 1'b0, ext_b = 1'b0, sleep = 1'b0;
   logic       ctrl_we = 1'b0;
   logic [7:0] ctrl_wd = '0;
   logic       lo_we = 1'b0, hi_we = 1'b0;
   logic [7:0] cnt_wd = '0;
   logic       ovf_we = 1'b0, ovf_wd = 1'b0;
   logic [7:0] cnt_lo, cnt_hi;
   logic       ovf;

   int errors = 0;
   int checks = 0;
   bit use_a  = 1'b0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   tmr_presc_counter u0 (
      .clk(clk), .rst_n(rst_n), .ext_a_i(ext_a), .ext_b_i(ext_b), .sleep_i(sleep),
      .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wd), .cnt_lo_we_i(lo_we),
      .cnt_hi_we_i(hi_we), .cnt_wdata_i(cnt_wd), .ovf_we_i(ovf_we),
      .ovf_wdata_i(ovf_wd), .cnt_lo_o(cnt_lo), .cnt_hi_o(cnt_hi), .ovf_o(ovf));

   // control byte: run b0, ext b1, bypass b2, pin-select b3, prescale b5:4
   function automatic logic [7:0] mk_ctrl(bit run, bit ext, bit byp, bit pa, int ps);
      return {2'b00, 2'(ps), pa, byp, ext, run};
   endfunction

   function automatic int exp_inc(int edges, int ps);
      int n = 1 << ps;
      return (edges + (n >> 1)) / n;
   endfunction

   function automatic int count_now();
      return {cnt_hi, cnt_lo};
   endfunction

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wr_ctrl(logic [7:0] v);
      ctrl_wd = v; ctrl_we = 1'b1; tick(1); ctrl_we = 1'b0;
   endtask

   task automatic wr_count(logic [7:0] lo, logic [7:0] hi);
      cnt_wd = lo; lo_we = 1'b1; tick(1); lo_we = 1'b0;
      cnt_wd = hi; hi_we = 1'b1; tick(1); hi_we = 1'b0;
   endtask

   // drive the selected pin; the other pin carries noise
   task automatic pulse(int hi_t, int lo_t);
      for (int i = 0; i < hi_t + lo_t; i++) begin
         if (use_a) begin ext_a = (i < hi_t); ext_b = 1'($urandom); end
         else       begin ext_b = (i < hi_t); ext_a = 1'($urandom); end
         tick(1);
      end
      ext_a = 1'b0; ext_b = 1'b0;
   endtask

   task automatic pulses(int n);
      for (int i = 0; i < n; i++) pulse(6, 6);
      tick(10);
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("  Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int c0;
      void'($urandom(32'h5EED_0017));
      tick(3);
      // R1 reset state
      chk("R1 count", count_now(), 0);
      chk("R1 ovf", ovf, 0);
      rst_n = 1'b1;
      tick(20);
      chk("R1 stopped after reset", count_now(), 0);

      // R10 byte loads
      wr_count(8'h5A, 8'hC3);
      chk("R10 byte load", count_now(), 16'hC35A);

      // R2 internal rate, bypass bit both ways
      for (int byp = 0; byp < 2; byp++) begin
         wr_ctrl(mk_ctrl(1, 0, byp[0], 0, 0));
         wr_count(8'h00, 8'h00);
         c0 = count_now();
         tick(400);
         chk("R2 rate", count_now() - c0, 100);
      end

      // R5 internal source holds in sleep
      sleep = 1'b1; tick(2);
      c0 = count_now(); tick(100);
      chk("R5 timer sleep", count_now() - c0, 0);
      sleep = 1'b0;

      // R8 stopped in external mode
      wr_ctrl(mk_ctrl(0, 1, 1, 0, 0));
      wr_count(0, 0); tick(4);
      pulses(3);
      chk("R8 run off", count_now(), 0);

      // R6 sleep edges lost, prescaler keeps counting (divide by 2)
      use_a = 1'b1;
      wr_ctrl(mk_ctrl(1, 1, 0, 1, 1));
      wr_count(0, 0); tick(4);
      sleep = 1'b1; tick(2);
      pulses(1);
      sleep = 1'b0; tick(4);
      chk("R6 no count in sleep", count_now(), 0);
      pulses(1);
      chk("R6 prescaler advanced in sleep", count_now(), 0);
      pulses(1);
      chk("R6 counts after wake", count_now(), 1);

      // R11 prescale rewrite clears partial progress (divide by 4)
      wr_ctrl(mk_ctrl(1, 1, 1, 1, 2));
      wr_count(0, 0); tick(4);
      pulses(1);
      wr_ctrl(mk_ctrl(1, 1, 1, 1, 3));
      wr_ctrl(mk_ctrl(1, 1, 1, 1, 2));
      tick(4);
      pulses(1);
      chk("R11 prescaler cleared", count_now(), 0);
      // R10 count write clears prescaler
      cnt_wd = 8'h00; lo_we = 1'b1; tick(1); lo_we = 1'b0; tick(4);
      pulses(1);
      chk("R10 prescaler cleared by write", count_now(), 0);

      // R3 R4 R5 R7 random mix
      for (int it = 0; it < 16; it++) begin
         bit byp = 1'($urandom);
         int ps  = int'($urandom % 4);
         int e   = 1 + int'($urandom % 12);
         bit slp = byp & 1'($urandom);
         use_a = 1'($urandom);
         wr_ctrl(mk_ctrl(1, 1, byp, use_a, ps));
         wr_count(0, 0); tick(4);
         sleep = slp;
         pulses(e);
         sleep = 1'b0;
         chk(byp ? (slp ? "R5 unsync count in sleep" : "R3 R4 unsync count")
                 : "R7 R4 sync count", count_now(), exp_inc(e, ps));
      end

      // R9 overflow
      wr_ctrl(mk_ctrl(0, 0, 0, 0, 0));
      wr_count(8'hFD, 8'hFF);
      chk("R9 no flag before wrap", ovf, 0);
      wr_ctrl(mk_ctrl(1, 0, 0, 0, 0));
      tick(24);
      chk("R9 flag on wrap", ovf, 1);
      chk("R9 count wrapped", (count_now() < 16) ? 1 : 0, 1);
      wr_ctrl(mk_ctrl(0, 0, 0, 0, 0));
      tick(10);
      chk("R9 flag sticky", ovf, 1);
      ovf_wd = 1'b0; ovf_we = 1'b1; tick(1); ovf_we = 1'b0; tick(1);
      chk("R9 flag cleared by write 0", ovf, 0);

      done = 1'b1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule